// File: doc/BRIEF.md
# Jump Target Sentry Checker

This block judges one capability jump-to-register instruction per transfer. It looks at the source and destination register indices, the sealing type of the target capability and the interrupt-enable state in force. From the operand pattern alone it tells a function return, a tail call (or jump-table jump) and a call apart. It accepts only the sealing types allowed for that pattern. It then reports whether to trap, the interrupt state after the jump, whether a link value is written and how that link is sealed, and whether the program counter takes the unsealed target address.

Requests come in on a valid/ready stream, and verdicts leave on a second valid/ready stream through a single register stage. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when it is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the verdict is held unchanged and no new request is taken. The upstream side must keep its request fields stable while it waits.

Top module: `jump_sentry_check`

## Requirements
- R1: With source index 1 and destination index 0 (return pattern), only sealing types 4 (return, interrupts off) and 5 (return, interrupts on) are accepted, and an accepted return sets `irq_en_next` to 0 for type 4 and 1 for type 5.
- R2: With source index other than 1 and destination index 0 (tail pattern), only sealing types 0 (unsealed) and 1 (forward, inherit) are accepted.
- R3: With a destination index other than 0 and 1 (plain call), only sealing types 0 and 1 are accepted.
- R4: With destination index 1 (call through the return-address register), sealing types 0 to 3 are accepted, and an accepted type 2 sets `irq_en_next` to 0 while type 3 sets it to 1.
- R5: An accepted jump with sealing type 0 or 1 leaves `irq_en_next` equal to the `irq_en_cur` of that request.
- R6: An accepted jump with destination index other than 0 raises `link_wr`, with `link_seal` 5 when `irq_en_cur` was 1 and 4 when it was 0; otherwise `link_wr` is 0 and `link_seal` is 0.
- R7: A rejected jump raises `trap`, clears `pc_wr` and `link_wr`, drives `pc_next` to 0 and keeps `irq_en_next` equal to `irq_en_cur`. `trap_cause` is 3 for sealing types 6 or 7, 1 for any other rejected return pattern, and 2 for every other rejection. An accepted jump gives `trap_cause` 0.
- R8: An accepted jump raises `pc_wr` with `pc_next` equal to `tgt_addr`.
- R9: The verdict for a request taken at one edge is presented on the outputs with `out_valid` high after that edge; with `out_valid` high and `out_ready` low the outputs stay unchanged; `in_ready` equals `!out_valid || out_ready`.
- R10: During and right after reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| src_idx | input | IDX_W | Source register index |
| dst_idx | input | IDX_W | Destination (link) register index |
| tgt_seal | input | 3 | Sealing type of the jump target |
| tgt_addr | input | ADDR_W | Address carried by the target |
| irq_en_cur | input | 1 | Interrupt enable before the jump |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Downstream takes the verdict |
| trap | output | 1 | Control-flow trap |
| trap_cause | output | 2 | 0 none, 1 bad return, 2 bad forward, 3 reserved type |
| irq_en_next | output | 1 | Interrupt enable after the jump |
| link_wr | output | 1 | Link value is written |
| link_seal | output | 3 | Sealing type of the link value |
| pc_wr | output | 1 | Program counter takes pc_next |
| pc_next | output | ADDR_W | Unsealed target address |

## Verification
A call through the return-address register with an interrupt-changing forward sentry does two things in one verdict. It sets the new interrupt state, and it seals a link that must capture the old state. Every combination of sealing type 2 or 3 with both values of `irq_en_cur` is driven through that pattern. The bench then checks that `link_seal` follows the previous enable while `irq_en_next` follows the sentry. Output back-pressure and a new request also meet in the same cycle when `out_ready` rises with `in_valid` high. Random ready patterns provoke this, and the reference model judges whether the held verdict was replaced or kept.

// File: rtl/jsc_pkg.sv
package jsc_pkg;

  // sealing type codes of a jump target
  localparam logic [2:0] SEAL_NONE        = 3'd0;
  localparam logic [2:0] SEAL_FWD_INHERIT = 3'd1;
  localparam logic [2:0] SEAL_FWD_IRQ_OFF = 3'd2;
  localparam logic [2:0] SEAL_FWD_IRQ_ON  = 3'd3;
  localparam logic [2:0] SEAL_RET_IRQ_OFF = 3'd4;
  localparam logic [2:0] SEAL_RET_IRQ_ON  = 3'd5;

  // trap cause codes
  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_RET  = 2'd1;
  localparam logic [1:0] CAUSE_FWD  = 2'd2;
  localparam logic [1:0] CAUSE_RSVD = 2'd3;

  typedef enum logic [1:0] {
    JK_RETURN     = 2'd0,
    JK_TAIL       = 2'd1,
    JK_CALL_OTHER = 2'd2,
    JK_CALL_RA    = 2'd3
  } jump_kind_e;

  typedef struct packed {
    logic       trap;
    logic [1:0] cause;
    logic       irq_en;
    logic       link_wr;
    logic [2:0] link_seal;
    logic       pc_wr;
  } verdict_t;

endpackage

// File: rtl/jump_classify.sv
module jump_classify #(
  parameter int IDX_W    = 5,
  parameter int NULL_IDX = 0,
  parameter int RA_IDX   = 1
) (
  input  logic [IDX_W-1:0]   src_idx,
  input  logic [IDX_W-1:0]   dst_idx,
  output jsc_pkg::jump_kind_e kind
);
  import jsc_pkg::*;

  localparam logic [IDX_W-1:0] NullI = IDX_W'(NULL_IDX);
  localparam logic [IDX_W-1:0] RaI   = IDX_W'(RA_IDX);

  logic dst_null, dst_ra, src_ra;

  assign dst_null = (dst_idx == NullI);
  assign dst_ra   = (dst_idx == RaI);
  assign src_ra   = (src_idx == RaI);

  always_comb begin
    if (dst_null) begin
      kind = src_ra ? JK_RETURN : JK_TAIL;
    end else if (dst_ra) begin
      kind = JK_CALL_RA;
    end else begin
      kind = JK_CALL_OTHER;
    end
  end
endmodule

// File: rtl/seal_policy.sv
module seal_policy (
  input  jsc_pkg::jump_kind_e kind,
  input  logic [2:0]          seal,
  input  logic                irq_cur,
  output jsc_pkg::verdict_t   verdict
);
  import jsc_pkg::*;

  // allowed-type masks, one bit per sealing code, built per kind
  logic [7:0] allow_mask [4];

  genvar gs;
  generate
    for (gs = 0; gs < 8; gs++) begin : g_mask
      localparam logic [2:0] Code = 3'(gs);
      assign allow_mask[JK_RETURN][gs]     = (Code == SEAL_RET_IRQ_OFF) || (Code == SEAL_RET_IRQ_ON);
      assign allow_mask[JK_TAIL][gs]       = (Code == SEAL_NONE) || (Code == SEAL_FWD_INHERIT);
      assign allow_mask[JK_CALL_OTHER][gs] = (Code == SEAL_NONE) || (Code == SEAL_FWD_INHERIT);
      assign allow_mask[JK_CALL_RA][gs]    = (Code <= SEAL_FWD_IRQ_ON);
    end
  endgenerate

  logic ok, reserved, links;

  assign reserved = (seal > SEAL_RET_IRQ_ON);
  assign ok       = allow_mask[kind][seal];
  assign links    = (kind == JK_CALL_OTHER) || (kind == JK_CALL_RA);

  always_comb begin
    verdict = '0;
    verdict.trap  = !ok;
    verdict.pc_wr = ok;
    if (reserved) begin
      verdict.cause = CAUSE_RSVD;
    end else if (!ok) begin
      verdict.cause = (kind == JK_RETURN) ? CAUSE_RET : CAUSE_FWD;
    end else begin
      verdict.cause = CAUSE_NONE;
    end

    verdict.irq_en = irq_cur;
    if (ok) begin
      unique case (seal)
        SEAL_FWD_IRQ_OFF, SEAL_RET_IRQ_OFF: verdict.irq_en = 1'b0;
        SEAL_FWD_IRQ_ON,  SEAL_RET_IRQ_ON:  verdict.irq_en = 1'b1;
        default:                            verdict.irq_en = irq_cur;
      endcase
    end

    verdict.link_wr   = ok && links;
    verdict.link_seal = (ok && links) ? (irq_cur ? SEAL_RET_IRQ_ON : SEAL_RET_IRQ_OFF)
                                      : SEAL_NONE;
  end
endmodule

// File: rtl/jump_out_stage.sv
module jump_out_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  jsc_pkg::verdict_t verdict_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic              out_valid,
  input  logic              out_ready,
  output jsc_pkg::verdict_t verdict_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      verdict_q <= '0;
      addr_q    <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        verdict_q <= verdict_d;
        addr_q    <= verdict_d.pc_wr ? addr_d : '0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/jump_sentry_check.sv
module jump_sentry_check #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 5,
  parameter int NULL_IDX = 0,
  parameter int RA_IDX   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [2:0]        tgt_seal,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              irq_en_cur,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              trap,
  output logic [1:0]        trap_cause,
  output logic              irq_en_next,
  output logic              link_wr,
  output logic [2:0]        link_seal,
  output logic              pc_wr,
  output logic [ADDR_W-1:0] pc_next
);
  import jsc_pkg::*;

  jump_kind_e kind;
  verdict_t   verdict_d, verdict_q;

  jump_classify #(
    .IDX_W   (IDX_W),
    .NULL_IDX(NULL_IDX),
    .RA_IDX  (RA_IDX)
  ) u_classify (
    .src_idx(src_idx),
    .dst_idx(dst_idx),
    .kind   (kind)
  );

  seal_policy u_policy (
    .kind   (kind),
    .seal   (tgt_seal),
    .irq_cur(irq_en_cur),
    .verdict(verdict_d)
  );

  jump_out_stage #(
    .ADDR_W(ADDR_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .verdict_d(verdict_d),
    .addr_d   (tgt_addr),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .verdict_q(verdict_q),
    .addr_q   (pc_next)
  );

  assign trap        = verdict_q.trap;
  assign trap_cause  = verdict_q.cause;
  assign irq_en_next = verdict_q.irq_en;
  assign link_wr     = verdict_q.link_wr;
  assign link_seal   = verdict_q.link_seal;
  assign pc_wr       = verdict_q.pc_wr;
endmodule

// File: rtl/jump_sentry_check_sva.sv
module jump_sentry_check_sva #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IDX_W-1:0]  src_idx,
  input logic [IDX_W-1:0]  dst_idx,
  input logic [2:0]        tgt_seal,
  input logic              irq_en_cur,
  input logic              out_valid,
  input logic              out_ready,
  input logic              trap,
  input logic [1:0]        trap_cause,
  input logic              irq_en_next,
  input logic              link_wr,
  input logic [2:0]        link_seal,
  input logic              pc_wr,
  input logic [ADDR_W-1:0] pc_next
);
  logic take;
  assign take = in_valid && in_ready;

  // R1
  ret_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && src_idx == IDX_W'(1) && dst_idx == '0 && tgt_seal == 3'd5
    |=> out_valid && !trap && irq_en_next);

  // R3
  call_rejects_irq_sentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && dst_idx > IDX_W'(1) && tgt_seal == 3'd2
    |=> out_valid && trap && trap_cause == 2'd2);

  // R6
  link_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && link_wr |-> (link_seal == 3'd4 || link_seal == 3'd5) && !trap);

  // R7
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap |-> !pc_wr && !link_wr && trap_cause != 2'd0 && pc_next == '0);

  // R9
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(trap) && $stable(trap_cause)
      && $stable(irq_en_next) && $stable(link_seal) && $stable(pc_next));

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind jump_sentry_check jump_sentry_check_sva #(
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .src_idx    (src_idx),
  .dst_idx    (dst_idx),
  .tgt_seal   (tgt_seal),
  .irq_en_cur (irq_en_cur),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .trap       (trap),
  .trap_cause (trap_cause),
  .irq_en_next(irq_en_next),
  .link_wr    (link_wr),
  .link_seal  (link_seal),
  .pc_wr      (pc_wr),
  .pc_next    (pc_next)
);

// File: tb/jump_sentry_check_test.sv
module jump_sentry_check_test;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [IDX_W-1:0]  src_idx;
  logic [IDX_W-1:0]  dst_idx;
  logic [2:0]        tgt_seal;
  logic [ADDR_W-1:0] tgt_addr;
  logic              irq_en_cur;
  logic              out_valid;
  logic              out_ready;
  logic              trap;
  logic [1:0]        trap_cause;
  logic              irq_en_next;
  logic              link_wr;
  logic [2:0]        link_seal;
  logic              pc_wr;
  logic [ADDR_W-1:0] pc_next;

  jump_sentry_check #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_idx(src_idx), .dst_idx(dst_idx), .tgt_seal(tgt_seal), .tgt_addr(tgt_addr),
    .irq_en_cur(irq_en_cur), .out_valid(out_valid), .out_ready(out_ready),
    .trap(trap), .trap_cause(trap_cause), .irq_en_next(irq_en_next),
    .link_wr(link_wr), .link_seal(link_seal), .pc_wr(pc_wr), .pc_next(pc_next)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic              m_valid = 1'b0;
  logic              e_trap, e_irq, e_lwr, e_pcwr;
  logic [1:0]        e_cause;
  logic [2:0]        e_lseal;
  logic [ADDR_W-1:0] e_pc;
  string             e_tag = "R9";

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected verdict, written from the requirement list
  task automatic predict(input int s, input int d, input int seal, input logic [ADDR_W-1:0] a,
                         input logic irq);
    bit ok;
    if (d == 0 && s == 1) begin
      ok = (seal == 4 || seal == 5); e_tag = "R1";                 // R1
    end else if (d == 0) begin
      ok = (seal == 0 || seal == 1); e_tag = "R2";                 // R2
    end else if (d != 1) begin
      ok = (seal == 0 || seal == 1); e_tag = "R3";                 // R3
    end else begin
      ok = (seal <= 3); e_tag = "R4";                              // R4
    end
    if (!ok) e_tag = "R7";
    e_trap = !ok;
    e_pcwr = ok;                                                   // R8
    e_pc   = ok ? a : '0;
    if (seal > 5) e_cause = 2'd3;                                  // R7
    else if (!ok) e_cause = (d == 0 && s == 1) ? 2'd1 : 2'd2;
    else e_cause = 2'd0;
    e_irq = irq;                                                   // R5
    if (ok && (seal == 2 || seal == 4)) e_irq = 1'b0;
    if (ok && (seal == 3 || seal == 5)) e_irq = 1'b1;
    e_lwr   = ok && d != 0;                                        // R6
    e_lseal = e_lwr ? (irq ? 3'd5 : 3'd4) : 3'd0;
  endtask

  task automatic step(input logic v, input int s, input int d, input int seal,
                      input logic [ADDR_W-1:0] a, input logic irq, input logic rdy);
    @(negedge clk);
    chk("R9", "out_valid", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      chk(e_tag, "trap", 64'(trap), 64'(e_trap));
      chk(e_tag, "trap_cause", 64'(trap_cause), 64'(e_cause));
      chk(e_tag, "irq_en_next", 64'(irq_en_next), 64'(e_irq));
      chk("R6", "link_wr", 64'(link_wr), 64'(e_lwr));
      chk("R6", "link_seal", 64'(link_seal), 64'(e_lseal));
      chk("R8", "pc_wr", 64'(pc_wr), 64'(e_pcwr));
      chk("R8", "pc_next", 64'(pc_next), 64'(e_pc));
    end
    in_valid   = v;
    src_idx    = IDX_W'(s);
    dst_idx    = IDX_W'(d);
    tgt_seal   = 3'(seal);
    tgt_addr   = a;
    irq_en_cur = irq;
    out_ready  = rdy;
    #1;
    chk("R9", "in_ready", 64'(in_ready), 64'(!m_valid || rdy));
    if (v && (!m_valid || rdy)) begin
      predict(s, d, seal, a, irq);
      m_valid = 1'b1;
    end else if (rdy) begin
      m_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_idx = '0; dst_idx = '0; tgt_seal = '0;
    tgt_addr = '0; irq_en_cur = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R10", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "out_valid after reset", 64'(out_valid), 64'd0);

    // every pattern x sealing type x enable, with downstream always ready
    for (int s = 1; s <= 2; s++)
      for (int di = 0; di < 3; di++)
        for (int seal = 0; seal < 8; seal++)
          for (int irq = 0; irq < 2; irq++) begin
            int d;
            d = (di == 0) ? 0 : (di == 1) ? 1 : 7;
            step(1'b1, s, d, seal, ADDR_W'(32'h1000 + seal * 16 + s), irq[0], 1'b1);
          end

    // R4 with R6: interrupt-changing call sentries, both prior states, back to back
    step(1'b1, 3, 1, 2, 32'hA000_0010, 1'b1, 1'b1);
    step(1'b1, 3, 1, 3, 32'hA000_0020, 1'b0, 1'b1);
    step(1'b1, 3, 1, 2, 32'hA000_0030, 1'b0, 1'b1);
    step(1'b1, 3, 1, 3, 32'hA000_0040, 1'b1, 1'b1);

    // R9 back-pressure: verdict held while a new request waits
    step(1'b1, 1, 0, 5, 32'hB000_0000, 1'b0, 1'b0);
    step(1'b1, 2, 0, 0, 32'hB000_0100, 1'b1, 1'b0);
    step(1'b1, 2, 0, 0, 32'hB000_0100, 1'b1, 1'b0);
    step(1'b1, 2, 0, 0, 32'hB000_0100, 1'b1, 1'b1);
    step(1'b0, 0, 0, 0, '0, 1'b0, 1'b1);

    // random traffic with random back-pressure
    for (int i = 0; i < 4000; i++) begin
      logic v, irq, rdy;
      int s, d, seal;
      v    = ($urandom % 4) != 0;
      s    = $urandom % 4;
      d    = $urandom % 4;
      seal = $urandom % 8;
      irq  = $urandom % 2;
      rdy  = ($urandom % 3) != 0;
      step(v, s, d, seal, ADDR_W'($urandom), irq, rdy);
    end

    step(1'b0, 0, 0, 0, '0, 1'b0, 1'b1);
    step(1'b0, 0, 0, 0, '0, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule